// File: doc/BRIEF.md
# Dual-Port RAM with Address-Collision Arbitration

This block is a synchronous memory with two ports, left and right, that behave the same way. Each port has a select, a write strobe, a read-drive enable, an address, write data and read data. Either port may write while the other reads. When both ports are selected on the same address at the same time, they collide. The block then grants the location to one port and raises a busy flag toward the other port. While that flag is raised, writes from the flagged port are dropped.

A mode input sets the block's role. When `master` is high, the block arbitrates on its own and drives the busy flags. When `master` is low, the block does no arbitration and drives its busy outputs low. It then only obeys the busy inputs that an external arbiter drives. This lets several of these blocks be placed side by side to widen the word, with one of them deciding for all. Reads have one cycle of latency. The read data is zero unless the port was selected and read-enabled in the previous cycle.

Top module: `dpram_arb`

## Requirements
- R1: After reset, both busy outputs and both read-data outputs are 0.
- R2: A read is a cycle with `x_en`=1 and `x_we`=0. In the cycle after a read with `x_oe`=1, `x_rdata` holds the word stored at `x_addr`. In the cycle after any other cycle (`x_en`=0, `x_oe`=0 or `x_we`=1), `x_rdata` is 0.
- R3: In master mode, suppose both ports are selected on equal addresses and neither port held that address with `x_en`=1 in the previous cycle. Then the left port wins. `r_busy` is 1 and `l_busy` is 0 in that same cycle. The two busy outputs are never 1 together.
- R4: In master mode, a port that was already selected on an address in the previous cycle wins against a port that newly arrives on that address. The newcomer's busy output is 1 from the first cycle of the match.
- R5: A write (`x_en`=1, `x_we`=1) from a port whose effective busy is 1 does not change memory. The winning port's write in the same cycle does change memory.
- R6: In master mode, a busy output stays 1 for exactly one cycle after the match ends. A match ends when the addresses differ or either port deselects. The busy output is 0 in the cycle after that.
- R7: In slave mode (`master`=0), both busy outputs are 0 and no arbitration takes place. A port's write is dropped exactly when its `x_busy_in` is 1, and reads are never blocked.
- R8: After one port writes a word, the opposite port reads that new word from the same address in any later cycle.
- R9: Ports on different addresses never raise busy, and both may write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1: block arbitrates; 0: busy taken from x_busy_in |
| l_en | input | 1 | Left port select |
| l_we | input | 1 | Left write strobe |
| l_oe | input | 1 | Left read-drive enable |
| l_addr | input | AW | Left address |
| l_wdata | input | WIDTH | Left write data |
| l_busy_in | input | 1 | Left busy from external arbiter (slave mode) |
| l_busy | output | 1 | Left busy flag (master mode) |
| l_rdata | output | WIDTH | Left read data |
| r_en | input | 1 | Right port select |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right read-drive enable |
| r_addr | input | AW | Right address |
| r_wdata | input | WIDTH | Right write data |
| r_busy_in | input | 1 | Right busy from external arbiter (slave mode) |
| r_busy | output | 1 | Right busy flag (master mode) |
| r_rdata | output | WIDTH | Right read data |

## Verification
The arbiter is tried with four address patterns. In the first, both ports write to distinct addresses, which shows that arbitration stays idle without a match. In the second, both ports land on one address in the same cycle, which tests the fixed left priority. In the third, the right port is already resident on an address when the left port arrives, which separates "first to arrive" from plain priority. The last pattern runs in slave mode with the external busy driven, which shows that the block stops arbitrating and only gates writes. Read-back through the opposite port then confirms which of the colliding writes reached memory. The cycles just after a match ends confirm the one-cycle hold on busy.

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 18,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             l_en,
  input  logic             l_we,
  input  logic             l_oe,
  input  logic [AW-1:0]    l_addr,
  input  logic [WIDTH-1:0] l_wdata,
  input  logic             l_busy_in,
  output logic             l_busy,
  output logic [WIDTH-1:0] l_rdata,
  input  logic             r_en,
  input  logic             r_we,
  input  logic             r_oe,
  input  logic [AW-1:0]    r_addr,
  input  logic [WIDTH-1:0] r_wdata,
  input  logic             r_busy_in,
  output logic             r_busy,
  output logic [WIDTH-1:0] r_rdata
);
  typedef enum logic [1:0] {OWN_NONE, OWN_L, OWN_R} own_t;

  logic [WIDTH-1:0] mem [DEPTH];
  own_t own_q, own_d;
  logic l_en_q, r_en_q;
  logic [AW-1:0] l_addr_q, r_addr_q;

  logic match, l_held, r_held, r_first, fresh, grant_l, grant_r;
  logic l_blk, r_blk, l_wr, r_wr;

  assign match   = l_en & r_en & (l_addr == r_addr);
  assign l_held  = l_en_q & (l_addr_q == l_addr);
  assign r_held  = r_en_q & (r_addr_q == r_addr);
  assign r_first = r_held & ~l_held;
  assign fresh   = master & match & (own_q == OWN_NONE);
  assign grant_l = (own_q == OWN_L) | (fresh & ~r_first);
  assign grant_r = (own_q == OWN_R) | (fresh & r_first);

  assign l_busy = master & grant_r;
  assign r_busy = master & grant_l;
  assign l_blk  = master ? grant_r : l_busy_in;
  assign r_blk  = master ? grant_l : r_busy_in;
  assign l_wr   = l_en & l_we & ~l_blk;
  assign r_wr   = r_en & r_we & ~r_blk;

  always_comb begin
    if (!master || !match) own_d = OWN_NONE;
    else if (own_q != OWN_NONE) own_d = own_q;
    else own_d = r_first ? OWN_R : OWN_L;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= OWN_NONE;
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      own_q    <= own_d;
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (r_wr) mem[r_addr] <= r_wdata;
    if (l_wr) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      l_rdata <= (l_en && l_oe && !l_we) ? mem[l_addr] : '0;
      r_rdata <= (r_en && r_oe && !r_we) ? mem[r_addr] : '0;
    end
  end
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int WIDTH = 18,
  parameter int AW = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master,
  input logic             l_en,
  input logic             l_we,
  input logic             l_oe,
  input logic [AW-1:0]    l_addr,
  input logic             l_busy,
  input logic [WIDTH-1:0] l_rdata,
  input logic             r_en,
  input logic             r_we,
  input logic             r_oe,
  input logic [AW-1:0]    r_addr,
  input logic             r_busy,
  input logic [WIDTH-1:0] r_rdata
);
  logic hit;
  assign hit = l_en && r_en && (l_addr == r_addr);

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n) !(l_busy && r_busy)); // R3
  AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !master |-> (!l_busy && !r_busy)); // R7
  AST_L_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(l_busy) |-> hit); // R4
  AST_R_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(r_busy) |-> hit); // R4
  AST_L_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (master && l_busy && !hit) |=> (!l_busy || hit)); // R6
  AST_R_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (master && r_busy && !hit) |=> (!r_busy || hit)); // R6
  AST_L_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n) !(l_en && l_oe && !l_we) |=> (l_rdata == '0)); // R2
  AST_R_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n) !(r_en && r_oe && !r_we) |=> (r_rdata == '0)); // R2
endmodule

bind dpram_arb dpram_arb_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master(master),
  .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_busy(l_busy), .l_rdata(l_rdata),
  .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_busy(r_busy), .r_rdata(r_rdata)
);

// File: tb/sim_dpram_arb.sv
`timescale 1ns/1ps
module sim_dpram_arb;
  localparam int W = 18;
  localparam int D = 1024;
  localparam int AW = 10;

  logic clk = 1'b0, rst_n = 1'b0, master = 1'b1;
  logic l_en = 0, l_we = 0, l_oe = 0, l_busy_in = 0, l_busy;
  logic r_en = 0, r_we = 0, r_oe = 0, r_busy_in = 0, r_busy;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [W-1:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;

  always #4 clk = ~clk;

  dpram_arb #(.DEPTH(D), .WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .master(master),
    .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_busy_in(l_busy_in), .l_busy(l_busy), .l_rdata(l_rdata),
    .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_busy_in(r_busy_in), .r_busy(r_busy), .r_rdata(r_rdata)
  );

  typedef struct { logic [W-1:0] v; string tag; } exp_t;
  exp_t lq[$], rq[$];
  logic l_issue = 0, r_issue = 0, l_chk = 0, r_chk = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    l_chk <= l_issue;
    r_chk <= r_issue;
  end

  always @(negedge clk) begin : monitor
    exp_t e;
    if (l_chk) begin
      if (lq.size() == 0) check("scoreboard left empty", 1, 0);
      else begin e = lq.pop_front(); check({"left ", e.tag}, l_rdata, e.v); end
    end
    if (r_chk) begin
      if (rq.size() == 0) check("scoreboard right empty", 1, 0);
      else begin e = rq.pop_front(); check({"right ", e.tag}, r_rdata, e.v); end
    end
  end

  task automatic l_drv(bit en, bit we, bit oe, logic [AW-1:0] a, logic [W-1:0] d);
    l_en = en; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
  endtask
  task automatic r_drv(bit en, bit we, bit oe, logic [AW-1:0] a, logic [W-1:0] d);
    r_en = en; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
  endtask
  task automatic l_exp(logic [W-1:0] v, string tag);
    lq.push_back('{v, tag}); l_issue = 1;
  endtask
  task automatic r_exp(logic [W-1:0] v, string tag);
    rq.push_back('{v, tag}); r_issue = 1;
  endtask
  task automatic tick();
    @(posedge clk); @(negedge clk);
    l_issue = 0; r_issue = 0;
  endtask
  task automatic idle();
    l_drv(0, 0, 0, 0, 0); r_drv(0, 0, 0, 0, 0); tick();
  endtask
  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 l_busy", l_busy, 0);
    check("R1 r_busy", r_busy, 0);
    check("R1 l_rdata", l_rdata, 0);
    check("R1 r_rdata", r_rdata, 0);

    l_drv(1, 1, 0, 5, 18'h00111); r_drv(1, 1, 0, 9, 18'h00222);
    #1 check("R9 l_busy distinct", l_busy, 0); check("R9 r_busy distinct", r_busy, 0);
    tick();
    l_drv(1, 0, 1, 9, 0); l_exp(18'h00222, "R8 cross read");
    r_drv(1, 0, 1, 5, 0); r_exp(18'h00111, "R8 cross read");
    tick();
    l_drv(1, 0, 0, 9, 0); l_exp(0, "R2 oe low");
    r_drv(0, 0, 1, 5, 0); r_exp(0, "R2 en low");
    tick();
    idle();
    l_drv(1, 1, 0, 30, 18'h00d0d); r_drv(1, 1, 0, 40, 18'h00f0f);
    tick();
    idle();

    l_drv(1, 1, 0, 20, 18'h00aaa); r_drv(1, 1, 0, 20, 18'h00bbb);
    #1 check("R3 r_busy tie", r_busy, 1); check("R3 l_busy tie", l_busy, 0);
    tick();
    l_drv(0, 0, 0, 0, 0); r_drv(0, 0, 0, 0, 0);
    #1 check("R6 r_busy hold", r_busy, 1);
    tick();
    #1 check("R6 r_busy release", r_busy, 0);
    r_drv(1, 0, 1, 20, 0); r_exp(18'h00aaa, "R5 winner write");
    tick();

    r_drv(1, 0, 1, 30, 0); r_exp(18'h00d0d, "R4 resident read");
    l_drv(1, 0, 0, 31, 0);
    tick();
    l_drv(1, 1, 0, 30, 18'h00c0c); r_drv(1, 0, 1, 30, 0); r_exp(18'h00d0d, "R4 read during win");
    #1 check("R4 l_busy late", l_busy, 1); check("R4 r_busy first", r_busy, 0);
    tick();
    #1 check("R5 l_busy held", l_busy, 1);
    tick();
    l_drv(0, 0, 0, 0, 0); r_drv(0, 0, 0, 0, 0);
    #1 check("R6 l_busy hold", l_busy, 1);
    tick();
    #1 check("R6 l_busy release", l_busy, 0);
    r_drv(1, 0, 1, 30, 0); r_exp(18'h00d0d, "R5 blocked write");
    tick();
    idle();

    master = 0; l_busy_in = 1;
    l_drv(1, 1, 0, 40, 18'h00e0e);
    #1 check("R7 l_busy slave", l_busy, 0);
    tick();
    l_busy_in = 0;
    l_drv(1, 0, 1, 40, 0); l_exp(18'h00f0f, "R7 write gated by busy input");
    tick();
    l_drv(1, 1, 0, 40, 18'h00e0e); r_drv(1, 0, 1, 40, 0); r_exp(18'h00f0f, "R7 old word same edge");
    #1 check("R7 l_busy no arb", l_busy, 0); check("R7 r_busy no arb", r_busy, 0);
    tick();
    r_busy_in = 1;
    l_drv(0, 0, 0, 0, 0); r_drv(1, 0, 1, 40, 0); r_exp(18'h00e0e, "R7 write accepted");
    tick();
    r_busy_in = 0;
    idle();
    idle();
    done = 1;
    summary();
    $finish;
  end
endmodule